// File: doc/BRIEF.md
# SPI FIFO Threshold and Interrupt Controller

This block sits between a serial shift engine and the register bus of an SPI controller. It keeps two byte queues of 64 entries each. The transmit queue is filled from the bus side and drained by the shift engine. The receive queue is filled by the shift engine and drained from the bus side. Each queue has a programmable level. When the receive queue reaches its level, the block raises a ready event. When the transmit queue falls to its level, the block raises a refill request. Either condition can also drive a DMA request line.

Software talks to the block through a small word-addressed register port with four registers: FIFO control, FIFO occupancy, interrupt enable and interrupt status. Status bits are sticky and are cleared by writing ones. A single interrupt line combines every pending status bit that is enabled. The control register can also flush either queue with a bit that clears itself. The shift engine reports the end of a transfer through a one-cycle input, and that input is latched into the status register.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: While rst_ni is low, all registers read 0, both queues are empty, and irq_o, rx_dma_req_o and tx_dma_req_o are 0.
- R2: Each queue returns bytes in the order they were accepted. The occupancy register (address 1) shows the receive count in bits 7:0 and the transmit count in bits 23:16. It is read-only, so writes to it are ignored.
- R3: A push into a full queue is dropped and leaves the contents unchanged. A pop from an empty queue is ignored. A receive push while the receive queue holds 64 bytes sets the overflow status bit (bit 8) at the next clock edge.
- R4: When the receive queue is non-empty and its count is at least the receive level (control bits 7:0), status bit 0 is set at the next clock edge.
- R5: When the transmit count is at or below the transmit level (control bits 23:16), status bit 4 is set at the next clock edge.
- R6: A one-cycle pulse on xfer_done_i sets status bit 12 at the next clock edge.
- R7: Writing to the status register (address 3) clears each bit written as 1 and leaves each bit written as 0 unchanged. If an event sets a bit in the same cycle as its clear, the bit stays set.
- R8: The enable register (address 2) uses the same bit positions as the status register. irq_o is 1 exactly when some status bit and its enable bit are both 1.
- R9: rx_dma_req_o equals control bit 8 ANDed with the receive condition of R4. tx_dma_req_o equals control bit 24 ANDed with the transmit condition of R5. Both follow the current counts without delay.
- R10: Writing 1 to control bit 15 empties the receive queue, and writing 1 to bit 31 empties the transmit queue, at the edge of that write. The written bit reads back 1 for the following cycle only and then reads 0.
- R11: Control bits 14:9 and 30:25 read 0. The enable and status registers read 0 outside bits 0, 4, 8 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 control, 1 occupancy, 2 enable, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| tx_push_i | input | 1 | Bus side writes a byte into the transmit queue |
| tx_push_data_i | input | 8 | Byte to queue for transmission |
| tx_pop_i | input | 1 | Shift engine takes the head transmit byte |
| tx_pop_data_o | output | 8 | Head of the transmit queue |
| rx_push_i | input | 1 | Shift engine delivers a received byte |
| rx_push_data_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Bus side takes the head received byte |
| rx_pop_data_o | output | 8 | Head of the receive queue |
| xfer_done_i | input | 1 | Transfer-complete pulse from the shift engine |
| irq_o | output | 1 | Combined interrupt |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |

## Verification
The queues are run through several patterns: short bursts of distinct bytes interleaved with pops, a receive fill to exactly 64 bytes followed by one extra byte, a transmit fill past capacity, and pops on an empty queue. A scoreboard separates correct ordering and dropping from pointer wrap faults. The level logic is stepped one byte at a time across each threshold, which separates a greater-or-equal compare from a strict compare and a level that sets as it is reached from one that sets a cycle late. The status register is then written with mixed one and zero patterns while some events are still active and others are not, so that clearing, retention and set-wins priority each show up in different bits.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  localparam int REG_W = 32;
  localparam int THR_W = 8;
  localparam int NEV   = 4;

  typedef enum logic [1:0] {
    A_FCTL = 2'd0,
    A_FSTA = 2'd1,
    A_IEN  = 2'd2,
    A_ISTA = 2'd3
  } sfq_addr_e;

  // control word field positions (software decodes these)
  localparam int RX_THR_LSB = 0;
  localparam int RX_DMA_BIT = 8;
  localparam int RX_RST_BIT = 15;
  localparam int TX_THR_LSB = 16;
  localparam int TX_DMA_BIT = 24;
  localparam int TX_RST_BIT = 31;
  localparam int RX_CNT_LSB = 0;
  localparam int TX_CNT_LSB = 16;

  // compact event vector index -> register bit position
  localparam int IX_RX_RDY = 0;
  localparam int IX_TX_REQ = 1;
  localparam int IX_RX_OVF = 2;
  localparam int IX_DONE   = 3;

  function automatic int ev_pos(input int ix);
    return ix * 4;
  endfunction

  function automatic logic [REG_W-1:0] ev_to_word(input logic [NEV-1:0] v);
    logic [REG_W-1:0] w;
    w = '0;
    for (int i = 0; i < NEV; i++) w[ev_pos(i)] = v[i];
    return w;
  endfunction

  function automatic logic [NEV-1:0] ev_from_word(input logic [REG_W-1:0] w);
    logic [NEV-1:0] v;
    for (int i = 0; i < NEV; i++) v[i] = w[ev_pos(i)];
    return v;
  endfunction
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          drop_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign drop_o  = push_i && full;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assign pop_data_o = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o    = cnt_q;
endmodule

// File: rtl/sfq_ctrl_regs.sv
module sfq_ctrl_regs
  import sfq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [THR_W-1:0] rx_thr_o,
  output logic [THR_W-1:0] tx_thr_o,
  output logic             rx_dma_o,
  output logic             tx_dma_o,
  output logic             rx_rst_o,
  output logic             tx_rst_o,
  output logic             rx_flush_o,
  output logic             tx_flush_o,
  output logic [NEV-1:0]   ien_o
);
  logic ctl_we, ien_we;
  logic unused_wbits;

  assign ctl_we     = we_i && (addr_i == A_FCTL);
  assign ien_we     = we_i && (addr_i == A_IEN);
  assign rx_flush_o = ctl_we && wdata_i[RX_RST_BIT];
  assign tx_flush_o = ctl_we && wdata_i[TX_RST_BIT];
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_thr_o <= '0;
      tx_thr_o <= '0;
      rx_dma_o <= 1'b0;
      tx_dma_o <= 1'b0;
      rx_rst_o <= 1'b0;
      tx_rst_o <= 1'b0;
      ien_o    <= '0;
    end else begin
      // reset flags are visible for exactly one cycle after the write
      rx_rst_o <= rx_flush_o;
      tx_rst_o <= tx_flush_o;
      if (ctl_we) begin
        rx_thr_o <= wdata_i[RX_THR_LSB +: THR_W];
        tx_thr_o <= wdata_i[TX_THR_LSB +: THR_W];
        rx_dma_o <= wdata_i[RX_DMA_BIT];
        tx_dma_o <= wdata_i[TX_DMA_BIT];
      end
      if (ien_we) ien_o <= ev_from_word(wdata_i);
    end
  end
endmodule

// File: rtl/sfq_event_status.sv
module sfq_event_status
  import sfq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CW-1:0]    rx_cnt_i,
  input  logic [CW-1:0]    tx_cnt_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic             rx_drop_i,
  input  logic             done_i,
  input  logic             clr_i,
  input  logic [NEV-1:0]   clr_mask_i,
  output logic [NEV-1:0]   sts_o,
  output logic             rx_hit_o,
  output logic             tx_hit_o
);
  localparam int XW = (CW > THR_W) ? CW : THR_W;

  logic [XW-1:0]  rx_cx, tx_cx, rx_tx, tx_tx;
  logic [NEV-1:0] set_v, sts_q;

  assign rx_cx = XW'(rx_cnt_i);
  assign tx_cx = XW'(tx_cnt_i);
  assign rx_tx = XW'(rx_thr_i);
  assign tx_tx = XW'(tx_thr_i);

  assign rx_hit_o = (rx_cx != '0) && (rx_cx >= rx_tx);
  assign tx_hit_o = (tx_cx <= tx_tx);

  always_comb begin
    set_v            = '0;
    set_v[IX_RX_RDY] = rx_hit_o;
    set_v[IX_TX_REQ] = tx_hit_o;
    set_v[IX_RX_OVF] = rx_drop_i;
    set_v[IX_DONE]   = done_i;
  end

  for (genvar g = 0; g < NEV; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[g] <= 1'b0;
      else         sts_q[g] <= set_v[g] | (sts_q[g] & ~(clr_i & clr_mask_i[g]));
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import sfq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_push_data_i,
  input  logic             tx_pop_i,
  output logic [DW-1:0]    tx_pop_data_o,
  input  logic             rx_push_i,
  input  logic [DW-1:0]    rx_push_data_i,
  input  logic             rx_pop_i,
  output logic [DW-1:0]    rx_pop_data_o,
  input  logic             xfer_done_i,
  output logic             irq_o,
  output logic             rx_dma_req_o,
  output logic             tx_dma_req_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    rx_cnt, tx_cnt;
  logic             rx_drop, tx_drop_unused;
  logic             rx_flush, tx_flush, rx_rst_q, tx_rst_q;
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic             rx_dma_en, tx_dma_en, rx_hit, tx_hit;
  logic [NEV-1:0]   ien, sts;

  sfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i     (tx_flush),
    .push_i      (tx_push_i),
    .push_data_i (tx_push_data_i),
    .pop_i       (tx_pop_i),
    .pop_data_o  (tx_pop_data_o),
    .count_o     (tx_cnt),
    .drop_o      (tx_drop_unused)
  );

  sfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i     (rx_flush),
    .push_i      (rx_push_i),
    .push_data_i (rx_push_data_i),
    .pop_i       (rx_pop_i),
    .pop_data_o  (rx_pop_data_o),
    .count_o     (rx_cnt),
    .drop_o      (rx_drop)
  );

  sfq_ctrl_regs u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rx_thr_o   (rx_thr),
    .tx_thr_o   (tx_thr),
    .rx_dma_o   (rx_dma_en),
    .tx_dma_o   (tx_dma_en),
    .rx_rst_o   (rx_rst_q),
    .tx_rst_o   (tx_rst_q),
    .rx_flush_o (rx_flush),
    .tx_flush_o (tx_flush),
    .ien_o      (ien)
  );

  sfq_event_status #(.CW(CW)) u_evt (
    .clk_i, .rst_ni,
    .rx_cnt_i   (rx_cnt),
    .tx_cnt_i   (tx_cnt),
    .rx_thr_i   (rx_thr),
    .tx_thr_i   (tx_thr),
    .rx_drop_i  (rx_drop),
    .done_i     (xfer_done_i),
    .clr_i      (reg_we_i && (reg_addr_i == A_ISTA)),
    .clr_mask_i (ev_from_word(reg_wdata_i)),
    .sts_o      (sts),
    .rx_hit_o   (rx_hit),
    .tx_hit_o   (tx_hit)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_FCTL: begin
        reg_rdata_o[RX_THR_LSB +: THR_W] = rx_thr;
        reg_rdata_o[RX_DMA_BIT]          = rx_dma_en;
        reg_rdata_o[RX_RST_BIT]          = rx_rst_q;
        reg_rdata_o[TX_THR_LSB +: THR_W] = tx_thr;
        reg_rdata_o[TX_DMA_BIT]          = tx_dma_en;
        reg_rdata_o[TX_RST_BIT]          = tx_rst_q;
      end
      A_FSTA: begin
        reg_rdata_o[RX_CNT_LSB +: THR_W] = THR_W'(rx_cnt);
        reg_rdata_o[TX_CNT_LSB +: THR_W] = THR_W'(tx_cnt);
      end
      A_IEN:   reg_rdata_o = ev_to_word(ien);
      default: reg_rdata_o = ev_to_word(sts);
    endcase
  end

  assign irq_o        = |(sts & ien);
  assign rx_dma_req_o = rx_dma_en && rx_hit;
  assign tx_dma_req_o = tx_dma_en && tx_hit;
endmodule

// File: rtl/spi_fifo_irq_ctrl_chk.sv
module spi_fifo_irq_ctrl_chk
  import sfq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             rx_push_i,
  input logic             xfer_done_i,
  input logic             irq_o,
  input logic             rx_dma_req_o,
  input logic [CW-1:0]    rx_cnt,
  input logic [CW-1:0]    tx_cnt,
  input logic [THR_W-1:0] rx_thr,
  input logic [THR_W-1:0] tx_thr,
  input logic [NEV-1:0]   sts,
  input logic [NEV-1:0]   ien
);
  a_r2_rx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(rx_cnt) <= DEPTH);
  a_r2_tx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_cnt) <= DEPTH);
  a_r3_overflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && 32'(rx_cnt) == DEPTH) |=> sts[IX_RX_OVF]);
  a_r4_rx_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt != '0 && 32'(rx_cnt) >= 32'(rx_thr)) |=> sts[IX_RX_RDY]);
  a_r5_tx_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(tx_cnt) <= 32'(tx_thr)) |=> sts[IX_TX_REQ]);
  a_r6_done_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> sts[IX_DONE]);
  a_r8_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ((sts & ien) != '0));
  a_r9_rx_dma_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_req_o |-> (rx_cnt != '0));
  a_r10_rx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_FCTL && reg_wdata_i[RX_RST_BIT]) |=> (rx_cnt == '0));
endmodule

bind spi_fifo_irq_ctrl spi_fifo_irq_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .rx_push_i    (rx_push_i),
  .xfer_done_i  (xfer_done_i),
  .irq_o        (irq_o),
  .rx_dma_req_o (rx_dma_req_o),
  .rx_cnt       (rx_cnt),
  .tx_cnt       (tx_cnt),
  .rx_thr       (rx_thr),
  .tx_thr       (tx_thr),
  .sts          (sts),
  .ien          (ien)
);

// File: tb/spi_fifo_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_irq_ctrl_tb_top;
  localparam int DEPTH = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [7:0]  tx_push_data_i = '0, rx_push_data_i = '0;
  logic [7:0]  tx_pop_data_o, rx_pop_data_o;
  logic        xfer_done_i = 1'b0;
  logic        irq_o, rx_dma_req_o, tx_dma_req_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #4 clk_i = ~clk_i;

  spi_fifo_irq_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare popped bytes against the scoreboard queues (R2)
  always @(negedge clk_i) begin
    if (tx_pop_i && txq.size() > 0) begin
      chk("R2 tx order", 32'(tx_pop_data_o), 32'(txq[0]));
      void'(txq.pop_front());
    end
    if (rx_pop_i && rxq.size() > 0) begin
      chk("R2 rx order", 32'(rx_pop_data_o), 32'(rxq[0]));
      void'(rxq.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_we_i = 1'b0; reg_wdata_i = '0;
    if (a == 2'd0 && d[15]) rxq.delete();
    if (a == 2'd0 && d[31]) txq.delete();
  endtask

  task automatic rd_now(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(posedge clk_i); @(negedge clk_i);
    rd_now(a, d);
  endtask

  task automatic smp;
    @(posedge clk_i); @(negedge clk_i); #1;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(posedge clk_i); #1;
    tx_push_i = 1'b1; tx_push_data_i = b;
    if (txq.size() < DEPTH) txq.push_back(b);
    @(posedge clk_i); #1;
    tx_push_i = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(posedge clk_i); #1;
    rx_push_i = 1'b1; rx_push_data_i = b;
    if (rxq.size() < DEPTH) rxq.push_back(b);
    @(posedge clk_i); #1;
    rx_push_i = 1'b0;
  endtask

  task automatic pop_tx;
    @(posedge clk_i); #1; tx_pop_i = 1'b1;
    @(posedge clk_i); #1; tx_pop_i = 1'b0;
  endtask

  task automatic pop_rx;
    @(posedge clk_i); #1; rx_pop_i = 1'b1;
    @(posedge clk_i); #1; rx_pop_i = 1'b0;
  endtask

  task automatic done_pulse;
    @(posedge clk_i); #1; xfer_done_i = 1'b1;
    @(posedge clk_i); #1; xfer_done_i = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    // R1: reset state
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rd_now(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd_now(2'd1, v); chk("R1 occupancy", v, 32'h0);
    rd_now(2'd2, v); chk("R1 enable", v, 32'h0);
    rd_now(2'd3, v); chk("R1 status", v, 32'h0);
    chk("R1 outputs", {29'd0, irq_o, rx_dma_req_o, tx_dma_req_o}, 32'h0);
    @(posedge clk_i); #1; rst_ni = 1'b1;

    // R5: empty transmit queue is at or below level 0
    rd(2'd3, v); chk("R5 tx request after reset", v, 32'h10);
    // R7: clear while event still active -> set wins
    wr(2'd3, 32'h10);
    rd_now(2'd3, v); chk("R7 set wins over clear", v, 32'h10);

    wr(2'd0, 32'h0002_0000);
    for (int i = 0; i < 4; i++) push_tx(8'hA0 + 8'(i));
    wr(2'd3, 32'h10);
    rd(2'd3, v); chk("R5 above level clear", v & 32'h10, 32'h0);
    rd(2'd1, v); chk("R2 tx count", v, 32'h0004_0000);
    pop_tx();
    rd(2'd3, v); chk("R5 count 3 level 2", v & 32'h10, 32'h0);
    pop_tx();
    rd(2'd3, v); chk("R5 count 2 level 2", v & 32'h10, 32'h10);
    pop_tx(); pop_tx();
    pop_tx();  // empty: ignored
    rd(2'd1, v); chk("R3 pop on empty ignored", v, 32'h0);

    // R4 / R9: receive level 3 with receive DMA
    wr(2'd0, 32'h0002_0103);
    push_rx(8'h11); push_rx(8'h22);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R4 below level", v & 32'h1, 32'h0);
    chk("R9 rx dma below level", 32'(rx_dma_req_o), 32'h0);
    push_rx(8'h33);
    rd(2'd3, v); chk("R4 level reached", v & 32'h1, 32'h1);
    chk("R9 rx dma at level", 32'(rx_dma_req_o), 32'h1);
    pop_rx();
    smp(); chk("R9 rx dma drops", 32'(rx_dma_req_o), 32'h0);
    chk("R9 tx dma disabled", 32'(tx_dma_req_o), 32'h0);
    wr(2'd0, 32'h0102_0103);
    smp(); chk("R9 tx dma enabled", 32'(tx_dma_req_o), 32'h1);
    wr(2'd0, 32'h0002_0103);
    smp(); chk("R9 tx dma off", 32'(tx_dma_req_o), 32'h0);
    pop_rx(); pop_rx();

    // R3: receive overflow
    wr(2'd3, 32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i * 3 + 1));
    rd(2'd3, v); chk("R3 no overflow at 64", v & 32'h100, 32'h0);
    push_rx(8'hEE);
    rd(2'd3, v); chk("R3 overflow flag", v & 32'h100, 32'h100);
    rd(2'd1, v); chk("R3 rx count full", v, 32'h0000_0040);
    for (int i = 0; i < DEPTH; i++) pop_rx();
    rd(2'd1, v); chk("R3 rx drained", v, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) push_tx(8'(i + 7));
    rd(2'd1, v); chk("R3 tx full drop", v, 32'h0040_0000);

    // R10: self-clearing flush of both queues
    push_rx(8'h5A); push_rx(8'h5B);
    wr(2'd0, 32'h8002_8003);
    rd_now(2'd0, v); chk("R10 reset bits visible", v, 32'h8002_8003);
    rd(2'd0, v); chk("R10 reset bits cleared", v, 32'h0002_0003);
    rd(2'd1, v); chk("R10 queues emptied", v, 32'h0);
    push_rx(8'h55); pop_rx();
    push_tx(8'h66); pop_tx();

    // R6 / R8 / R7
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_1000);
    smp(); chk("R8 pending but masked", 32'(irq_o), 32'h0);
    done_pulse();
    rd(2'd3, v); chk("R6 done latched", v & 32'h1000, 32'h1000);
    chk("R8 irq on enabled event", 32'(irq_o), 32'h1);
    wr(2'd3, 32'h10);
    rd(2'd3, v); chk("R7 zero bit retained", v & 32'h1000, 32'h1000);
    wr(2'd3, 32'h1000);
    rd(2'd3, v); chk("R7 one bit cleared", v & 32'h1000, 32'h0);
    chk("R8 irq low after clear", 32'(irq_o), 32'h0);

    // R11 / R2: read-only occupancy and reserved bits
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R2 occupancy read-only", v, 32'h0);
    rd(2'd2, v); chk("R11 enable unaffected", v, 32'h0000_1000);
    wr(2'd0, 32'h7E02_7E03);
    rd(2'd0, v); chk("R11 reserved ctrl bits", v, 32'h0002_0003);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R11 enable bits", v, 32'h0000_1111);

    repeat (4) @(posedge clk_i);
    summary();
  end
endmodule